// File: doc/BRIEF.md
# Split-Carry Phase Accumulator Oscillator

This block is a numerically controlled oscillator. On every clock it adds a frequency word to a phase word, modulo the full phase width. The most significant phase bit is a square wave whose average frequency is the clock frequency scaled by the frequency word over 2^PHASE_W. Any single output period is a whole number of clocks: either the floor or the ceiling of the ideal period.

The accumulator is split into a lower and an upper half so that no cycle needs a carry chain across the full phase width. The lower half's carry out goes into a flip-flop, and the upper half uses that registered carry on the next clock. The upper bits of the frequency word are delayed one clock to match the carry. The lower bits of the sum are delayed one clock before they are joined with the upper half on the phase output. Each half feeds back straight from its own register. With these delays the assembled phase is exactly the sequence an unsplit accumulator would produce, one clock later. This holds even while the frequency word changes every cycle.

Top module: `split_nco`

## Requirements
- R1: After reset, `phase_o` on every cycle equals a plain full-width accumulator (reset to zero, adding `freq_word` on each clock modulo 2^PHASE_W), delayed by exactly one clock.
- R2: The registered carry into the upper half is 1 exactly when the previous lower-half addition wrapped past 2^LO_W. A frequency word of 0x00008000 gives phase 0x00010000 two cycles after the first addition.
- R3: The upper PHASE_W-LO_W bits of `freq_word` reach the upper adder one clock after the lower bits reach the lower adder. A word applied for only one clock still enters the phase exactly once.
- R4: The lower LO_W bits of `phase_o` are the lower accumulator delayed by one register stage. The lower half's own feedback does not pass through that delay.
- R5: `rst` is synchronous and active high. It clears every register, so `phase_o` is 0 and `clk_o` is 0 on the clock after a reset edge.
- R6: `clk_o` always equals bit PHASE_W-1 of `phase_o`.
- R7: `freq_word` may change on any cycle, and R1 still holds for the same word sequence.
- R8: The phase wraps modulo 2^PHASE_W. A word of 0xFFFFFFFF held for n additions gives phase 2^32-n, and a word of 0x80000000 held for two additions gives 0.
- R9: With word 906238099 held, every `clk_o` period (rising edge to rising edge) is 4 or 5 clocks, and 3000 clocks hold 632 to 634 rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | PHASE_W | Frequency (phase increment) word, sampled every clock |
| phase_o | output | PHASE_W | Assembled phase word, one clock behind the ideal accumulator |
| clk_o | output | 1 | Oscillator output, the phase MSB |

## Verification
The assertions assume `rst` is held for at least one clock edge before normal operation. They assume `freq_word` is a known value at every sampling edge, because the carry and skew checks compare registered state with the previous cycle's inputs. The bench changes `freq_word` only at falling clock edges and never leaves it undriven. It starts every scenario with a reset pulse that spans a rising edge. The random section changes the word on most cycles, so the assertions see both held and changing words.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned PHASE_W_DEF = 32;
  localparam int unsigned LO_W_DEF    = 16;
endpackage

// File: rtl/nco_pipe_reg.sv
module nco_pipe_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= d;
  end

  assign q = q_r;
endmodule

// File: rtl/nco_lo_acc.sv
module nco_lo_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] step,
  output logic [W-1:0] acc_o,
  output logic         cy_o
);
  logic [W:0]   sum_w;
  logic [W-1:0] acc_r;
  logic         cy_r;
  logic         armed_r;

  assign sum_w = {1'b0, acc_r} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_r   <= '0;
      cy_r    <= 1'b0;
      armed_r <= 1'b0;
    end else begin
      acc_r   <= sum_w[W-1:0];
      cy_r    <= sum_w[W];
      armed_r <= 1'b1;
    end
  end

  assign acc_o = acc_r;
  assign cy_o  = cy_r;

  AST_CARRY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    armed_r |-> (cy_r == (acc_r < $past(acc_r)))); // R2
endmodule

// File: rtl/nco_hi_acc.sv
module nco_hi_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] step,
  input  logic         cy_i,
  output logic [W-1:0] acc_o
);
  logic [W-1:0] acc_r;

  always_ff @(posedge clk) begin
    if (rst) acc_r <= '0;
    else     acc_r <= acc_r + step + {{(W-1){1'b0}}, cy_i};
  end

  assign acc_o = acc_r;
endmodule

// File: rtl/split_nco.sv
module split_nco
  import nco_pkg::*;
#(
  parameter int unsigned PHASE_W = PHASE_W_DEF,
  parameter int unsigned LO_W    = LO_W_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] freq_word,
  output logic [PHASE_W-1:0] phase_o,
  output logic               clk_o
);
  localparam int unsigned HI_W = PHASE_W - LO_W;

  logic [LO_W-1:0] lo_acc;
  logic [LO_W-1:0] lo_out;
  logic            lo_cy;
  logic [HI_W-1:0] hi_step;
  logic [HI_W-1:0] hi_acc;
  logic            armed_r;

  nco_lo_acc #(.W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .step(freq_word[LO_W-1:0]),
    .acc_o(lo_acc), .cy_o(lo_cy)
  );

  nco_pipe_reg #(.W(HI_W)) u_hi_skew (
    .clk(clk), .rst(rst), .d(freq_word[PHASE_W-1:LO_W]), .q(hi_step)
  );

  nco_hi_acc #(.W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .step(hi_step), .cy_i(lo_cy), .acc_o(hi_acc)
  );

  nco_pipe_reg #(.W(LO_W)) u_lo_align (
    .clk(clk), .rst(rst), .d(lo_acc), .q(lo_out)
  );

  assign phase_o = {hi_acc, lo_out};
  assign clk_o   = hi_acc[HI_W-1];

  always_ff @(posedge clk) begin
    if (rst) armed_r <= 1'b0;
    else     armed_r <= 1'b1;
  end

  AST_HI_STEP_SKEW: assert property (@(posedge clk) disable iff (rst)
    armed_r |-> (hi_step == $past(freq_word[PHASE_W-1:LO_W]))); // R3
  AST_LO_ALIGN: assert property (@(posedge clk) disable iff (rst)
    armed_r |-> (phase_o[LO_W-1:0] == $past(lo_acc))); // R4
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (phase_o == '0 && !clk_o)); // R5
  AST_OUT_IS_MSB: assert property (@(posedge clk) disable iff (rst)
    clk_o == phase_o[PHASE_W-1]); // R6
endmodule

// File: tb/split_nco_test.sv
module split_nco_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] inc = '0;
  logic [31:0] phase;
  logic        nco_clk;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 0;
  logic [31:0] ref_q, ref_d;

  split_nco uut (.clk(clk), .rst(rst), .freq_word(inc), .phase_o(phase), .clk_o(nco_clk));

  always #5 clk = ~clk;

  // behavioural full-width accumulator and its one-clock delay
  always @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      ref_d <= '0;
    end else begin
      ref_q <= ref_q + inc;
      ref_d <= ref_q;
    end
  end

  localparam int NV = 8;
  localparam logic [31:0] V_INC [NV] = '{32'h0000_0001, 32'h0000_FFFF, 32'h0001_0000,
    32'hFFFF_FFFF, 32'h8000_0000, 32'h4000_0000, 32'h0000_8000, 32'h7FFF_FFFF};
  localparam int V_N [NV] = '{5, 3, 4, 3, 3, 6, 3, 4};
  localparam logic [31:0] V_EXP [NV] = '{32'h0000_0004, 32'h0001_FFFE, 32'h0003_0000,
    32'hFFFF_FFFE, 32'h0000_0000, 32'h4000_0000, 32'h0001_0000, 32'h7FFF_FFFD};
  localparam string V_TAG [NV] = '{"R1", "R2", "R3", "R8", "R8", "R8", "R2", "R8"};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [31:0] w);
    @(negedge clk);
    rst = 1'b1;
    inc = w;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // R5: reset state
    @(negedge clk);
    inc = 32'hDEAD_BEEF;
    @(negedge clk);
    chk(phase == 32'h0, "R5", phase, 32'h0);
    chk(nco_clk == 1'b0, "R5", {31'b0, nco_clk}, 32'h0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(phase == 32'h0, "R5", phase, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_reset(V_INC[i]);
      repeat (V_N[i]) @(negedge clk);
      chk(phase == V_EXP[i], V_TAG[i], phase, V_EXP[i]);
      chk(nco_clk == V_EXP[i][31], "R6", {31'b0, nco_clk}, {31'b0, V_EXP[i][31]});
    end

    // R3: upper word bits held for a single clock only
    do_reset(32'h0003_0000);
    @(negedge clk);
    inc = 32'h0;
    repeat (4) @(negedge clk);
    chk(phase == 32'h0003_0000, "R3", phase, 32'h0003_0000);

    // R4: a lower-only word shows up one clock after its addition
    do_reset(32'h0000_0100);
    @(negedge clk);
    inc = 32'h0;
    @(negedge clk);
    chk(phase == 32'h0000_0100, "R4", phase, 32'h0000_0100);

    // R1/R7: random words, changed on most cycles
    do_reset(32'h0);
    begin
      int errs = 0;
      logic [31:0] a = 0, e = 0;
      for (int c = 0; c < 3000; c++) begin
        if (phase !== ref_d || nco_clk !== ref_d[31]) begin
          if (errs == 0) begin a = phase; e = ref_d; end
          errs++;
        end
        if (($urandom % 4) != 0) inc = $urandom;
        @(negedge clk);
      end
      chk(errs == 0, "R7", a, e);
      chk(errs == 0, "R1", a, e);
    end

    // R9: period pattern for word 906238099
    do_reset(32'd906238099);
    begin
      int rises = 0, badp = 0, last = -1, worst = 0;
      logic prev = 1'b0;
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        if (nco_clk && !prev) begin
          rises++;
          if (last >= 0 && (c - last < 4 || c - last > 5)) begin
            badp++;
            worst = c - last;
          end
          last = c;
        end
        prev = nco_clk;
      end
      chk(badp == 0, "R9", worst, 32'd4);
      chk(rises >= 632 && rises <= 634, "R9", rises, 32'd633);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule